// File: doc/BRIEF.md
# Scaled 64-bit System Counter

This block keeps a 64-bit unsigned timestamp that advances once per counter tick. With scaling off, each tick adds one. With scaling on, each tick adds an unsigned fixed-point step with 8 integer bits and 24 fraction bits. The fraction part builds up in a hidden 24-bit remainder, and a carry out of that remainder adds one more to the count. There is one step register per clock source. The step in use follows the clock-source select input, so a clock switch needs no new programming.

Software reaches the block through a 32-bit register port. A register access is valid in the cycle that `bus_sel` is high. Read data and the error response come back combinationally in that same cycle. Writes take effect at the next clock edge.

A three-state run controller has these states:
- `CNT_OFF`: the enable bit is clear.
- `CNT_RUN`: the counter is counting.
- `CNT_HALT`: the counter is frozen by a debug halt.

Its transitions are:
- OFF→RUN: the enable bit is set.
- OFF→HALT: the enable bit is set while a halt is active.
- RUN→HALT: the halt condition rises.
- HALT→RUN: the halt condition is released.
- RUN→OFF and HALT→OFF: the enable bit is cleared.

The block sets an error flag on a bad access: either the security attribute is wrong or the word index is undecoded. From that flag it drives a maskable interrupt and an optional error response.

Top module: `scaled_syscnt`

## Requirements
- R1: After reset the count is 0, the control word is 0, both step registers read 0x01000000 (1.0), and `err_irq` is low.
- R2: When control bit 0 (enable) is clear, ticks leave the count unchanged.
- R3: When enabled with control bit 2 (scaling) clear, each edge with `tick` high adds exactly 1 to the count.
- R4: With scaling on, each tick adds the selected step register: bits 31:24 are the integer part, bits 23:0 the fraction, and a carry from the hidden fraction adds 1. `clk_sel`=0 selects the step register at word index 5, and `clk_sel`=1 selects the one at index 6.
- R5: While the enable bit is set and the write-override parameter is 0, writes to either step register are ignored.
- R6: When `dbg_halt_req` is high and control bit 1 (halt on debug) is set, ticks do not advance the count, and status bit 1 (word index 1) reads 1.
- R7: Writing the count low word (index 3) or high word (index 4) wins over a tick in the same cycle, and it clears the hidden fraction.
- R8: A carry out of the low word reaches the high word on the same edge.
- R9: An access whose `bus_secure` differs from the frame attribute, or that uses word index 7, has no effect, reads 0, and sets the error flag. `err_irq` equals that flag ANDed with control bit 3. Writing 1 to control bit 5 clears the flag, and bit 5 reads 0.
- R10: An error access drives `bus_slverr` high in the same cycle, unless control bit 4 is set.
- R11: The ID word (index 2) reads bit 0 = 1, bit 16 = clock switching present, bits 18:17 = `clk_sel`, and bit 19 = write override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter tick qualifier |
| clk_sel | input | SEL_W | Selected clock source, which picks the step register |
| dbg_halt_req | input | 1 | Debug halt request |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Security attribute of the access |
| bus_rdata | output | 32 | Read data, combinational |
| bus_slverr | output | 1 | Error response, combinational |
| err_irq | output | 1 | Masked error interrupt |
| count | output | 64 | Current count |

## Verification
The bench targets five corner cases:
- Fraction carry: it uses steps of 1.5 and 0.25 across a clock-source change. A design that dropped the fraction carry, or that read the wrong step register, would land on 3 or 6 where 4 and 7 are expected.
- Count write during a tick: it writes the low word on a ticking edge, and rewrites the count while a half fraction is pending. A design that let the increment win, or that kept the old fraction, reads 0x101 or 0x42.
- Low-to-high carry: it checks the carry across the 32-bit word boundary.
- Step register lock: it checks that a step write is ignored while counting.
- Error handling: it checks the masking and clearing of the error flag, a write with the wrong security attribute that must not land, and suppression of the error response.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
    typedef enum logic [1:0] {
        CNT_OFF  = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_HALT = 2'd2
    } run_state_t;

    // control bit positions (software-visible)
    localparam int CTL_EN    = 0;
    localparam int CTL_HDBG  = 1;
    localparam int CTL_SCALE = 2;
    localparam int CTL_IRQM  = 3;
    localparam int CTL_NOSLV = 4;
    localparam int CTL_ICLR  = 5;
    localparam int CTL_W     = 5;

    // word indices
    localparam int REG_CTRL   = 0;
    localparam int REG_STAT   = 1;
    localparam int REG_ID     = 2;
    localparam int REG_CNT_LO = 3;
    localparam int REG_CNT_HI = 4;
    localparam int REG_SCALE0 = 5;

    localparam logic [31:0] SCALE_ONE = 32'h0100_0000;
endpackage

// File: rtl/sysctr_fsm.sv
module sysctr_fsm
    import sysctr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hdbg,
    input  logic dbg_halt_req,
    output logic run_ok,
    output logic halted
);
    run_state_t state_q, state_d;
    logic       halt_cond;

    assign halt_cond = hdbg && dbg_halt_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_OFF:  if (en) state_d = halt_cond ? CNT_HALT : CNT_RUN;
            CNT_RUN:  if (!en) state_d = CNT_OFF;
                      else if (halt_cond) state_d = CNT_HALT;
            CNT_HALT: if (!en) state_d = CNT_OFF;
                      else if (!halt_cond) state_d = CNT_RUN;
            default:  state_d = CNT_OFF;
        endcase
    end

    always_comb begin
        run_ok = (state_q == CNT_RUN) && en && !halt_cond;
        halted = (state_q == CNT_HALT);
    end
endmodule

// File: rtl/sysctr_accum.sv
module sysctr_accum #(
    parameter int CNT_W  = 64,
    parameter int REG_W  = 32,
    parameter int INT_W  = 8,
    parameter int FRAC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    scale_en,
    input  logic [INT_W+FRAC_W-1:0] scale_val,
    input  logic                    wr_lo,
    input  logic                    wr_hi,
    input  logic [REG_W-1:0]        wr_data,
    output logic [CNT_W-1:0]        count
);
    localparam int HI_W = CNT_W - REG_W;

    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W:0]   frac_sum;
    logic [CNT_W-1:0]  inc;

    assign frac_sum = {1'b0, frac_q} + {1'b0, scale_val[FRAC_W-1:0]};
    assign inc = scale_en
        ? CNT_W'(scale_val[INT_W+FRAC_W-1:FRAC_W]) + CNT_W'(frac_sum[FRAC_W])
        : CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            frac_q <= '0;
        end else if (wr_lo) begin
            count[REG_W-1:0] <= wr_data;
            frac_q           <= '0;
        end else if (wr_hi) begin
            count[CNT_W-1:REG_W] <= HI_W'(wr_data);
            frac_q               <= '0;
        end else if (step) begin
            count <= count + inc;
            if (scale_en) frac_q <= frac_sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/sysctr_regs.sv
module sysctr_regs
    import sysctr_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter int NUM_SRC      = 2,
    parameter int SEL_W        = $clog2(NUM_SRC),
    parameter bit FRAME_SECURE = 1'b1,
    parameter bit SCALE_WR_OVR = 1'b0,
    parameter bit CLK_SWITCH   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_secure,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              halted,
    input  logic [63:0]       count,
    output logic [31:0]       bus_rdata,
    output logic              bus_slverr,
    output logic              err_irq,
    output logic              ctrl_en,
    output logic              ctrl_hdbg,
    output logic              ctrl_scale,
    output logic              ctrl_mask,
    output logic [31:0]       scale_sel_val,
    output logic              wr_lo,
    output logic              wr_hi
);
    localparam int LAST_IDX = REG_SCALE0 + NUM_SRC;

    logic [CTL_W-1:0]             ctrl_q;
    logic                         err_q;
    logic                         acc_err, acc_ok, wr_ok, scale_open;
    logic [NUM_SRC-1:0][31:0]     scale_arr;
    logic [31:0]                  rd_mux, id_word;
    logic [1:0]                   sel2;

    assign acc_err    = bus_sel && ((bus_secure != FRAME_SECURE) ||
                                    (32'(bus_addr) >= 32'(LAST_IDX)));
    assign acc_ok     = bus_sel && !acc_err;
    assign wr_ok      = acc_ok && bus_wr;
    assign scale_open = SCALE_WR_OVR || !ctrl_q[CTL_EN];
    assign wr_lo      = wr_ok && (bus_addr == ADDR_W'(REG_CNT_LO));
    assign wr_hi      = wr_ok && (bus_addr == ADDR_W'(REG_CNT_HI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ok && bus_addr == ADDR_W'(REG_CTRL))
                ctrl_q <= bus_wdata[CTL_W-1:0];
            if (acc_err)
                err_q <= 1'b1;
            else if (wr_ok && bus_addr == ADDR_W'(REG_CTRL) && bus_wdata[CTL_ICLR])
                err_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_scale
        logic [31:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= SCALE_ONE;
            else if (wr_ok && scale_open && bus_addr == ADDR_W'(REG_SCALE0 + g))
                val_q <= bus_wdata;
        end
        assign scale_arr[g] = val_q;
    end

    assign sel2          = 2'(clk_sel);
    assign scale_sel_val = scale_arr[clk_sel];
    assign id_word       = {12'd0, SCALE_WR_OVR, sel2, CLK_SWITCH, 15'd0, 1'b1};

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(REG_CTRL))   rd_mux = 32'(ctrl_q);
        if (bus_addr == ADDR_W'(REG_STAT))   rd_mux = {30'd0, halted, 1'b0};
        if (bus_addr == ADDR_W'(REG_ID))     rd_mux = id_word;
        if (bus_addr == ADDR_W'(REG_CNT_LO)) rd_mux = count[31:0];
        if (bus_addr == ADDR_W'(REG_CNT_HI)) rd_mux = count[63:32];
        for (int g = 0; g < NUM_SRC; g++)
            if (bus_addr == ADDR_W'(REG_SCALE0 + g)) rd_mux = scale_arr[g];
    end

    assign bus_rdata  = (acc_ok && !bus_wr) ? rd_mux : 32'd0;
    assign bus_slverr = acc_err && !ctrl_q[CTL_NOSLV];
    assign ctrl_en    = ctrl_q[CTL_EN];
    assign ctrl_hdbg  = ctrl_q[CTL_HDBG];
    assign ctrl_scale = ctrl_q[CTL_SCALE];
    assign ctrl_mask  = ctrl_q[CTL_IRQM];
    assign err_irq    = err_q && ctrl_q[CTL_IRQM];
endmodule

// File: rtl/scaled_syscnt.sv
module scaled_syscnt
    import sysctr_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter int NUM_SRC      = 2,
    parameter int SEL_W        = $clog2(NUM_SRC),
    parameter bit FRAME_SECURE = 1'b1,
    parameter bit SCALE_WR_OVR = 1'b0,
    parameter bit CLK_SWITCH   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic              dbg_halt_req,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_secure,
    output logic [31:0]       bus_rdata,
    output logic              bus_slverr,
    output logic              err_irq,
    output logic [63:0]       count
);
    logic        ctrl_en, ctrl_hdbg, ctrl_scale, ctrl_mask;
    logic        run_ok, halted, wr_lo, wr_hi;
    logic [31:0] scale_sel_val;

    sysctr_regs #(
        .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W),
        .FRAME_SECURE(FRAME_SECURE), .SCALE_WR_OVR(SCALE_WR_OVR),
        .CLK_SWITCH(CLK_SWITCH)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .clk_sel(clk_sel), .halted(halted), .count(count),
        .bus_rdata(bus_rdata), .bus_slverr(bus_slverr), .err_irq(err_irq),
        .ctrl_en(ctrl_en), .ctrl_hdbg(ctrl_hdbg), .ctrl_scale(ctrl_scale),
        .ctrl_mask(ctrl_mask), .scale_sel_val(scale_sel_val),
        .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    sysctr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .hdbg(ctrl_hdbg),
        .dbg_halt_req(dbg_halt_req), .run_ok(run_ok), .halted(halted)
    );

    sysctr_accum #(.CNT_W(64), .REG_W(32), .INT_W(8), .FRAC_W(24)) u_acc (
        .clk(clk), .rst_n(rst_n), .step(tick && run_ok),
        .scale_en(ctrl_scale), .scale_val(scale_sel_val),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(bus_wdata), .count(count)
    );
endmodule

// File: rtl/scaled_syscnt_chk.sv
module scaled_syscnt_chk #(
    parameter bit SCALE_WR_OVR = 1'b0,
    parameter int SEL_W        = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [SEL_W-1:0] clk_sel,
    input logic             bus_sel,
    input logic [31:0]      bus_wdata,
    input logic             bus_slverr,
    input logic             err_irq,
    input logic [63:0]      count,
    input logic             ctrl_en,
    input logic             ctrl_scale,
    input logic             ctrl_mask,
    input logic             run_ok,
    input logic             halted,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic [31:0]      scale_sel_val
);
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en && !wr_lo && !wr_hi |=> $stable(count));

    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok && tick && !ctrl_scale && !wr_lo && !wr_hi
        |=> count == $past(count) + 64'd1);

    a_r5_scale_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !SCALE_WR_OVR && ctrl_en && $past(ctrl_en) && $stable(clk_sel)
        |-> $stable(scale_sel_val));

    a_r6_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !wr_lo && !wr_hi |=> $stable(count));

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> count[31:0] == $past(bus_wdata));

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> ctrl_mask);

    a_r10_slverr_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_slverr |-> bus_sel);
endmodule

bind scaled_syscnt scaled_syscnt_chk #(.SCALE_WR_OVR(SCALE_WR_OVR), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clk_sel(clk_sel),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_slverr(bus_slverr),
    .err_irq(err_irq), .count(count), .ctrl_en(ctrl_en),
    .ctrl_scale(ctrl_scale), .ctrl_mask(ctrl_mask), .run_ok(run_ok),
    .halted(halted), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .scale_sel_val(scale_sel_val)
);

// File: tb/scaled_syscnt_test.sv
`timescale 1ns/1ps
module scaled_syscnt_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick = 0;
    logic [0:0]  clk_sel = '0;
    logic        dbg_halt_req = 0;
    logic        bus_sel = 0, bus_wr = 0, bus_secure = 1;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_slverr, err_irq;
    logic [63:0] count;

    int total = 0, bad = 0;
    bit done = 0;

    logic [31:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    scaled_syscnt uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clk_sel(clk_sel),
        .dbg_halt_req(dbg_halt_req), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_rdata(bus_rdata), .bus_slverr(bus_slverr), .err_irq(err_irq),
        .count(count)
    );

    // monitor: compare each read against the oldest expected item
    always @(negedge clk) begin
        if (bus_sel && !bus_wr && q_data.size() > 0) begin
            logic [31:0] ed;
            logic        ee;
            string       et;
            ed = q_data.pop_front();
            ee = q_err.pop_front();
            et = q_tag.pop_front();
            total++;
            if (bus_rdata !== ed || bus_slverr !== ee) begin
                bad++;
                $display("FAIL %s: rdata=%h slverr=%b expected rdata=%h slverr=%b",
                         et, bus_rdata, bus_slverr, ed, ee);
            end
        end
    end

    task automatic bus_op(input logic wr, input logic [2:0] a,
                          input logic [31:0] d, input logic sec);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_secure = sec;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_secure = 1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_op(1'b1, a, d, 1'b1);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp_d,
                      input logic exp_e, input string tag);
        q_data.push_back(exp_d); q_err.push_back(exp_e); q_tag.push_back(tag);
        bus_op(1'b0, a, 32'd0, 1'b1);
    endtask

    task automatic pulse_ticks(input int n);
        @(posedge clk); #1; tick = 1;
        repeat (n) @(posedge clk);
        #1; tick = 0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        total++;
        if (err_irq !== exp) begin
            bad++;
            $display("FAIL %s: err_irq=%b expected %b", tag, err_irq, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(3'd0, 32'h0, 1'b0, "R1 ctrl");
        rd(3'd5, 32'h0100_0000, 1'b0, "R1 scale0");
        rd(3'd3, 32'h0, 1'b0, "R1 count");
        chk_irq(1'b0, "R1 irq");
        // R2 disabled
        pulse_ticks(4);
        rd(3'd3, 32'h0, 1'b0, "R2 off hold");
        // R3 unit step
        wr(3'd0, 32'h1);
        pulse_ticks(5);
        rd(3'd3, 32'd5, 1'b0, "R3 unit step");
        // R7 write beats tick on the same edge
        @(posedge clk); #1;
        tick = 1; bus_sel = 1; bus_wr = 1; bus_addr = 3'd3; bus_wdata = 32'h100;
        @(posedge clk); #1;
        tick = 0; bus_sel = 0; bus_wr = 0;
        rd(3'd3, 32'h100, 1'b0, "R7 write wins");
        // R8 low to high carry
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd4, 32'h5);
        pulse_ticks(3);
        rd(3'd4, 32'h6, 1'b0, "R8 high word");
        rd(3'd3, 32'h1, 1'b0, "R8 low word");
        // R4 scaled steps
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h0180_0000);
        wr(3'd6, 32'h0040_0000);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h5);
        pulse_ticks(3);
        rd(3'd3, 32'd4, 1'b0, "R4 three steps of 1.5");
        pulse_ticks(1);
        rd(3'd3, 32'd6, 1'b0, "R4 fraction carry");
        clk_sel = 1'b1;
        pulse_ticks(4);
        rd(3'd3, 32'd7, 1'b0, "R4 source 1 quarter steps");
        rd(3'd2, 32'h0003_0001, 1'b0, "R11 id word");
        clk_sel = 1'b0;
        // R5 lock while enabled
        wr(3'd5, 32'h0200_0000);
        rd(3'd5, 32'h0180_0000, 1'b0, "R5 scale locked");
        pulse_ticks(2);
        rd(3'd3, 32'd10, 1'b0, "R5 old step still used");
        // R7 fraction cleared by write
        wr(3'd3, 32'h20);
        pulse_ticks(1);
        rd(3'd3, 32'h21, 1'b0, "R7 half pending");
        wr(3'd3, 32'h40);
        pulse_ticks(1);
        rd(3'd3, 32'h41, 1'b0, "R7 fraction cleared");
        // R6 halt on debug
        wr(3'd0, 32'h3);
        dbg_halt_req = 1;
        repeat (2) @(posedge clk);
        rd(3'd1, 32'h2, 1'b0, "R6 status halted");
        pulse_ticks(5);
        rd(3'd3, 32'h41, 1'b0, "R6 frozen");
        dbg_halt_req = 0;
        repeat (2) @(posedge clk);
        rd(3'd1, 32'h0, 1'b0, "R6 status released");
        pulse_ticks(2);
        rd(3'd3, 32'h43, 1'b0, "R6 resumes");
        // R9 / R10 errors
        rd(3'd7, 32'h0, 1'b1, "R10 undecoded slverr");
        chk_irq(1'b0, "R9 masked");
        wr(3'd0, 32'h0B);
        chk_irq(1'b1, "R9 unmasked");
        bus_op(1'b1, 3'd0, 32'h0, 1'b0);
        rd(3'd0, 32'h0B, 1'b0, "R9 insecure write ignored");
        wr(3'd0, 32'h2B);
        chk_irq(1'b0, "R9 cleared");
        rd(3'd0, 32'h0B, 1'b0, "R9 clear bit reads 0");
        wr(3'd0, 32'h1B);
        rd(3'd7, 32'h0, 1'b0, "R10 slverr suppressed");
        chk_irq(1'b1, "R9 flag set again");
        repeat (2) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule